// File: doc/BRIEF.md
# Pointer-Indexed Host Register Front End

This block is the host-facing register port of a serial bus controller. A host drives a 2-bit address, an 8-bit write byte and separate read and write strobes. Four direct locations are decoded. Location 0 means two different things. A read there returns the status byte reported by the serial engine. A write there loads an index pointer. Location 2 is a window onto whichever configuration register the pointer selects. Location 1 carries serial data to and from the engine. Location 3 holds the control byte. Control bit 3 is the serial-interrupt flag.

The configuration bank has seven registers, numbered by index:

| Index | Register | Reset value |
|---|---|---|
| 0 | transfer count | 0x00 |
| 1 | own address | 0x00 |
| 2 | clock-low period | 0x9D |
| 3 | clock-high period | 0x86 |
| 4 | timeout | 0xFF |
| 5 | preset / key | 0x00 |
| 6 | speed code | 0x00 |

All registers except the preset drive configuration outputs to the engine. The preset register also watches for a two-byte unlock key. When the key is complete, every register in the block returns to its reset value and a one-cycle core reset pulse goes out. An interrupt line tells the host that the engine needs attention.

Host reads are combinational from the address while the read strobe is high. A write takes effect at the rising clock edge on which the write strobe is high. The block has no back-pressure on this port: every strobed access completes in one cycle.

Top module: `ihr_host_top`

## Requirements
- R1: After `rst_n` is deasserted, the configuration outputs and indirect reads hold their reset values. These are count 0x00, own address 0x00, clock-low 0x9D, clock-high 0x86, timeout 0xFF, preset 0x00 and speed code 0x00. Control reads 0x00, and `irq`, `core_rst` and `eng_tx_load` are all 0.
- R2: A read at address 0 returns `eng_status`. A write at address 0 loads the pointer and changes no readable value. `host_rdata` is 0x00 while `host_rd` is low.
- R3: A write at address 2 stores the byte in the register at the pointer's index, for indexes 0 to 5. A read at address 2 returns that register. The pointer keeps its value across window accesses.
- R4: When the pointer is above 6, window reads return 0x00 and window writes change no register.
- R5: The speed code register at index 6 accepts the values 0, 1 and 2. A write of any larger value leaves it unchanged.
- R6: A write at address 1 drives its byte onto `eng_tx_data` and raises `eng_tx_load` for exactly the following cycle. A read at address 1 returns `eng_rx_data`.
- R7: A write at address 3 stores every control bit except bit 3. Bit 3 is set by `eng_si_set`. A host write of 0 to bit 3 clears it and a write of 1 to it has no effect. If a clear and `eng_si_set` arrive in the same cycle, the bit ends up set. A read at address 3 returns the control byte.
- R8: `irq` is 1 exactly while control bit 3 is set and `eng_status` differs from the idle code 0xF8.
- R9: When the preset index receives 0xA5 and then 0x5A, `core_rst` is 1 for exactly the cycle after the 0x5A write. From that same cycle, every register is back at its R1 value. Pointer writes between the two key bytes do not break the key.
- R10: A write at address 1, 2 or 3 between the two key bytes aborts the key, unless it is the completing 0x5A preset write. After an abort, 0x5A does not trigger the reset and is stored as a plain preset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Direct location select |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Write strobe, one write per high cycle |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read byte (0 when no read) |
| eng_status | input | 8 | Status code from the serial engine |
| eng_rx_data | input | 8 | Received byte from the engine |
| eng_si_set | input | 1 | Engine request to set the serial-interrupt flag |
| eng_tx_data | output | 8 | Byte handed to the engine |
| eng_tx_load | output | 1 | One-cycle pulse: new byte on eng_tx_data |
| ctrl_q | output | 8 | Control byte |
| cfg_count | output | 8 | Transfer count |
| cfg_own_addr | output | 8 | Own bus address |
| cfg_scl_lo | output | 8 | Clock-low period |
| cfg_scl_hi | output | 8 | Clock-high period |
| cfg_timeout | output | 8 | Timeout setting |
| cfg_mode | output | 2 | Speed code |
| irq | output | 1 | Interrupt to host |
| core_rst | output | 1 | One-cycle soft reset pulse |

## Verification
Two situations are hard to reach from the ports. The first is the key sequence with accesses between its two bytes. The bench interleaves pointer writes, which must keep the key alive, with a control write, which must kill it. It then checks `core_rst` on the cycle after the 0x5A write. The second is a flag clear that meets an engine set in the same cycle. The bench raises `eng_si_set` and a control write on the same falling edge, so both land on one rising edge.

// File: rtl/ihr_pkg.sv
package ihr_pkg;
  localparam int DW      = 8;
  localparam int NREG    = 7;
  localparam int MODE_W  = 2;
  localparam int MODE_MAX = 2;
  localparam int SI_BIT  = 3;

  localparam logic [DW-1:0] STATUS_IDLE = 8'hF8;
  localparam logic [DW-1:0] KEY_FIRST   = 8'hA5;
  localparam logic [DW-1:0] KEY_SECOND  = 8'h5A;

  typedef enum logic [1:0] {
    LOC_STAT_PTR = 2'd0,
    LOC_SDATA    = 2'd1,
    LOC_WINDOW   = 2'd2,
    LOC_CTRL     = 2'd3
  } loc_e;

  localparam int IDX_COUNT  = 0;
  localparam int IDX_OWN    = 1;
  localparam int IDX_LO     = 2;
  localparam int IDX_HI     = 3;
  localparam int IDX_TMO    = 4;
  localparam int IDX_PRESET = 5;
  localparam int IDX_MODE   = 6;

  function automatic logic [DW-1:0] reg_default(input int idx);
    case (idx)
      IDX_LO:  return 8'h9D;
      IDX_HI:  return 8'h86;
      IDX_TMO: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ihr_decode.sv
module ihr_decode
  import ihr_pkg::*;
(
  input  logic [1:0] addr,
  input  logic       wr,
  output logic       wr_ptr,
  output logic       wr_dat,
  output logic       wr_win,
  output logic       wr_ctl
);
  always_comb begin
    wr_ptr = wr && (loc_e'(addr) == LOC_STAT_PTR);
    wr_dat = wr && (loc_e'(addr) == LOC_SDATA);
    wr_win = wr && (loc_e'(addr) == LOC_WINDOW);
    wr_ctl = wr && (loc_e'(addr) == LOC_CTRL);
  end
endmodule

// File: rtl/ihr_cfg_bank.sv
module ihr_cfg_bank
  import ihr_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NREG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_win,
  input  logic [W-1:0]     ptr,
  input  logic [W-1:0]     wdata,
  output logic [N-1:0][W-1:0] regs,
  output logic [W-1:0]     win_rdata
);
  localparam int IW = $clog2(N);

  logic in_range;
  assign in_range = (ptr < W'(N));

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_win && (ptr == W'(i));
    if (i == IDX_MODE) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= reg_default(i);
        else if (clr)                              q <= reg_default(i);
        else if (hit && (wdata <= W'(MODE_MAX)))   q <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= reg_default(i);
        else if (clr)   q <= reg_default(i);
        else if (hit)   q <= wdata;
      end
    end
    assign regs[i] = q;
  end

  always_comb begin
    win_rdata = '0;
    if (in_range) win_rdata = regs[ptr[IW-1:0]];
  end
endmodule

// File: rtl/ihr_key_guard.sv
module ihr_key_guard
  import ihr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic          preset_wr,
  input  logic [DW-1:0] wdata,
  output logic          fire
);
  logic armed;

  assign fire = armed && preset_wr && (wdata == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  armed <= 1'b0;
    else if (fire)                               armed <= 1'b0;
    else if (preset_wr && (wdata == KEY_FIRST))  armed <= 1'b1;
    else if (data_wr)                            armed <= 1'b0;
  end
endmodule

// File: rtl/ihr_ctrl.sv
module ihr_ctrl
  import ihr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_ctl,
  input  logic          wr_dat,
  input  logic [DW-1:0] wdata,
  input  logic          si_set,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] ctl,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  output logic          irq
);
  logic [DW-1:0] ctl_nx;

  always_comb begin
    ctl_nx = ctl;
    if (wr_ctl) begin
      ctl_nx         = wdata;
      ctl_nx[SI_BIT] = ctl[SI_BIT] & wdata[SI_BIT];
    end
    if (si_set) ctl_nx[SI_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      tx_data <= '0;
      tx_load <= 1'b0;
    end else if (clr) begin
      ctl     <= '0;
      tx_data <= '0;
      tx_load <= 1'b0;
    end else begin
      ctl     <= ctl_nx;
      tx_load <= wr_dat;
      if (wr_dat) tx_data <= wdata;
    end
  end

  assign irq = ctl[SI_BIT] && (status != STATUS_IDLE);
endmodule

// File: rtl/ihr_host_top.sv
module ihr_host_top
  import ihr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] eng_status,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_si_set,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_load,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] cfg_count,
  output logic [DW-1:0] cfg_own_addr,
  output logic [DW-1:0] cfg_scl_lo,
  output logic [DW-1:0] cfg_scl_hi,
  output logic [DW-1:0] cfg_timeout,
  output logic [MODE_W-1:0] cfg_mode,
  output logic          irq,
  output logic          core_rst
);
  logic wr_ptr, wr_dat, wr_win, wr_ctl;
  logic [DW-1:0] ptr;
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0] win_rdata;
  logic fire;
  logic preset_wr;

  ihr_decode u_dec (
    .addr(host_addr), .wr(host_wr),
    .wr_ptr(wr_ptr), .wr_dat(wr_dat), .wr_win(wr_win), .wr_ctl(wr_ctl)
  );

  assign preset_wr = wr_win && (ptr == DW'(IDX_PRESET));

  ihr_key_guard u_key (
    .clk(clk), .rst_n(rst_n),
    .data_wr(wr_dat | wr_win | wr_ctl),
    .preset_wr(preset_wr), .wdata(host_wdata), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      core_rst <= 1'b0;
    end else begin
      core_rst <= fire;
      if (fire)        ptr <= '0;
      else if (wr_ptr) ptr <= host_wdata;
    end
  end

  ihr_cfg_bank #(.W(DW), .N(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(fire), .wr_win(wr_win),
    .ptr(ptr), .wdata(host_wdata), .regs(regs), .win_rdata(win_rdata)
  );

  ihr_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .clr(fire), .wr_ctl(wr_ctl), .wr_dat(wr_dat),
    .wdata(host_wdata), .si_set(eng_si_set), .status(eng_status),
    .ctl(ctrl_q), .tx_data(eng_tx_data), .tx_load(eng_tx_load), .irq(irq)
  );

  assign cfg_count    = regs[IDX_COUNT];
  assign cfg_own_addr = regs[IDX_OWN];
  assign cfg_scl_lo   = regs[IDX_LO];
  assign cfg_scl_hi   = regs[IDX_HI];
  assign cfg_timeout  = regs[IDX_TMO];
  assign cfg_mode     = regs[IDX_MODE][MODE_W-1:0];

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (loc_e'(host_addr))
        LOC_STAT_PTR: host_rdata = eng_status;
        LOC_SDATA:    host_rdata = eng_rx_data;
        LOC_WINDOW:   host_rdata = win_rdata;
        default:      host_rdata = ctrl_q;
      endcase
    end
  end
endmodule

// File: rtl/ihr_checker.sv
module ihr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] host_addr,
  input logic [7:0] host_wdata,
  input logic       host_wr,
  input logic [7:0] eng_status,
  input logic       eng_si_set,
  input logic [7:0] eng_tx_data,
  input logic       eng_tx_load,
  input logic [7:0] ctrl_q,
  input logic [7:0] cfg_scl_lo,
  input logic [7:0] cfg_scl_hi,
  input logic [1:0] cfg_mode,
  input logic       irq,
  input logic       core_rst
);
  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);

  assert_rst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (cfg_scl_lo == 8'h9D && cfg_scl_hi == 8'h86 && ctrl_q == 8'h00));

  assert_irq_not_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (eng_status != 8'hF8 && ctrl_q[3]));

  assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode != 2'd3);

  assert_tx_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1) |=> (eng_tx_load && eng_tx_data == $past(host_wdata)));

  assert_si_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd3 && !host_wdata[3] && !eng_si_set) |=> !ctrl_q[3]);

  assert_si_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_si_set |=> (ctrl_q[3] || core_rst));
endmodule

bind ihr_host_top ihr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_wr(host_wr), .eng_status(eng_status), .eng_si_set(eng_si_set),
  .eng_tx_data(eng_tx_data), .eng_tx_load(eng_tx_load), .ctrl_q(ctrl_q),
  .cfg_scl_lo(cfg_scl_lo), .cfg_scl_hi(cfg_scl_hi), .cfg_mode(cfg_mode),
  .irq(irq), .core_rst(core_rst)
);

// File: tb/sim_ihr_host_top.sv
module sim_ihr_host_top;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic [7:0] eng_status = 8'hF8;
  logic [7:0] eng_rx_data = 8'h00;
  logic       eng_si_set = 1'b0;
  logic [7:0] eng_tx_data;
  logic       eng_tx_load;
  logic [7:0] ctrl_q, cfg_count, cfg_own_addr, cfg_scl_lo, cfg_scl_hi, cfg_timeout;
  logic [1:0] cfg_mode;
  logic       irq, core_rst;

  int tests = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  ihr_host_top u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_status(eng_status), .eng_rx_data(eng_rx_data), .eng_si_set(eng_si_set),
    .eng_tx_data(eng_tx_data), .eng_tx_load(eng_tx_load), .ctrl_q(ctrl_q),
    .cfg_count(cfg_count), .cfg_own_addr(cfg_own_addr), .cfg_scl_lo(cfg_scl_lo),
    .cfg_scl_hi(cfg_scl_hi), .cfg_timeout(cfg_timeout), .cfg_mode(cfg_mode),
    .irq(irq), .core_rst(core_rst)
  );

  // {index, write byte, expected readback}
  localparam logic [23:0] VEC [10] = '{
    {8'd0, 8'h12, 8'h12},
    {8'd1, 8'h34, 8'h34},
    {8'd2, 8'h2C, 8'h2C},
    {8'd3, 8'h14, 8'h14},
    {8'd4, 8'h40, 8'h40},
    {8'd6, 8'h01, 8'h01},
    {8'd6, 8'h03, 8'h01},
    {8'd6, 8'h02, 8'h02},
    {8'd7, 8'h55, 8'h00},
    {8'd6, 8'hFF, 8'h02}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic iread(input logic [7:0] idx, output logic [7:0] d);
    hwrite(2'd0, idx);
    hread(2'd2, d);
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++; tests++;
    $display("FAIL watchdog: got 0x00 expected 0x01");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    iread(8'd2, r); check("R1 clock-low", r, 8'h9D);
    iread(8'd3, r); check("R1 clock-high", r, 8'h86);
    iread(8'd4, r); check("R1 timeout", r, 8'hFF);
    check("R1 count", cfg_count, 8'h00);
    hread(2'd3, r); check("R1 control", r, 8'h00);
    check("R1 irq/core_rst/load", {5'd0, irq, core_rst, eng_tx_load}, 8'h00);

    // R2 status and idle read strobe
    eng_status = 8'h08;
    hread(2'd0, r); check("R2 status", r, 8'h08);
    host_addr = 2'd0; #1 check("R2 no strobe", host_rdata, 8'h00);
    hwrite(2'd0, 8'd3);
    hread(2'd0, r); check("R2 status after ptr", r, 8'h08);

    // R3 R4 R5 vector walk
    for (int i = 0; i < 10; i++) begin
      hwrite(2'd0, VEC[i][23:16]);
      hwrite(2'd2, VEC[i][15:8]);
      hread(2'd2, r);
      check(VEC[i][23:16] > 8'd6 ? "R4 out of range" :
            (VEC[i][23:16] == 8'd6 ? "R5 mode" : "R3 window"), r, VEC[i][7:0]);
    end
    iread(8'd0, r); check("R4 idx0 untouched", r, 8'h12);
    check("R5 cfg_mode port", {6'd0, cfg_mode}, 8'h02);
    check("R3 own addr port", cfg_own_addr, 8'h34);

    // R6 serial data
    hwrite(2'd1, 8'hC3);
    check("R6 tx data", eng_tx_data, 8'hC3);
    check("R6 load pulse", {7'd0, eng_tx_load}, 8'h01);
    @(negedge clk);
    check("R6 load drops", {7'd0, eng_tx_load}, 8'h00);
    eng_rx_data = 8'h6E;
    hread(2'd1, r); check("R6 rx read", r, 8'h6E);

    // R7 R8 interrupt flag
    @(negedge clk); eng_si_set = 1'b1;
    @(negedge clk); eng_si_set = 1'b0;
    hread(2'd3, r); check("R7 si set", r, 8'h08);
    check("R8 irq busy", {7'd0, irq}, 8'h01);
    eng_status = 8'hF8; #1 check("R8 irq idle", {7'd0, irq}, 8'h00);
    eng_status = 8'h28; #1 check("R8 irq again", {7'd0, irq}, 8'h01);
    hwrite(2'd3, 8'h45);
    hread(2'd3, r); check("R7 clear keeps others", r, 8'h45);
    check("R8 irq after clear", {7'd0, irq}, 8'h00);
    hwrite(2'd3, 8'h08);
    hread(2'd3, r); check("R7 write one no effect", r, 8'h00);
    @(negedge clk);
    host_addr = 2'd3; host_wdata = 8'h40; host_wr = 1'b1; eng_si_set = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; eng_si_set = 1'b0;
    hread(2'd3, r); check("R7 set wins", r, 8'h48);

    // R10 aborted key
    hwrite(2'd0, 8'd5); hwrite(2'd2, 8'hA5);
    hwrite(2'd3, 8'h48);
    hwrite(2'd0, 8'd5); hwrite(2'd2, 8'h5A);
    check("R10 no reset", {7'd0, core_rst}, 8'h00);
    hread(2'd2, r); check("R10 preset stored", r, 8'h5A);
    iread(8'd2, r); check("R10 clock-low kept", r, 8'h2C);

    // R9 full key with pointer writes between
    hwrite(2'd0, 8'd5); hwrite(2'd2, 8'hA5);
    hwrite(2'd0, 8'd5); hwrite(2'd2, 8'h5A);
    check("R9 core_rst pulse", {7'd0, core_rst}, 8'h01);
    check("R9 clock-low default", cfg_scl_lo, 8'h9D);
    check("R9 mode default", {6'd0, cfg_mode}, 8'h00);
    check("R9 control default", ctrl_q, 8'h00);
    @(negedge clk);
    check("R9 pulse one cycle", {7'd0, core_rst}, 8'h00);
    iread(8'd0, r); check("R9 count default", r, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule